// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Controller

This block is the digital control core of a two-channel 12-bit converter. A host writes 16-bit words over a three-wire serial link (active-low select, clock, data). Each word is a 3-bit opcode, 12 payload bits and one trailing sub-bit. The word is decoded when select returns high. Each channel holds a staging register and an output register. Depending on the opcode, a word loads a staging register, updates one or both output registers, or puts channels into shutdown with a chosen output termination. A full power-down also turns off the shared bias.

The serial pins and an active-low load strobe are brought into the system clock through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. While the strobe is held low, each output register follows its staging register. The strobe never wakes a channel. A word whose bit count is not 16, or whose sub-bit is 1, is thrown away and raises a one-cycle error pulse.

Top module: `dual_dac_ctrl`

## Requirements
- R1: Bits are sampled on each rising serial clock while select is low, first bit first. Word bits [15:13] are the opcode, [12:1] are payload D11..D0 and [0] is the sub-bit. The command takes effect after select rises.
- R2: While select is high, serial clock and data activity changes no state.
- R3: Opcode 010 writes the payload to staging A, and opcode 101 writes it to staging B. Neither touches the output registers or channel enables.
- R4: Opcode 001 (staging A) and opcode 110 (staging B) write the payload, then copy both staging registers into both output registers. Both channels and the bias wake.
- R5: Opcode 011 writes the payload into all four registers. Opcode 100 copies both staging registers into the output registers. Both forms wake both channels and the bias.
- R6: Under opcode 000, payload D11..D9 = 001 updates output A from staging A and wakes A. D11..D9 = 101 does the same for B. Either one turns the bias back on.
- R7: Opcode 111 disables both channels. D11 sets the termination select of A and D10 sets that of B (1 = high-resistance load, 0 = low-resistance load). The bias state is left as it was.
- R8: Under opcode 000, D11..D9 = 110 disables A only and D11..D9 = 111 disables B only. In both cases D8 is that channel's termination select.
- R9: Under opcode 000, D11..D9 = 011 is a full power-down. It disables the bias and both channels, with D8 as the A termination and D7 as the B termination. The bias is on whenever any channel is enabled.
- R10: While the load strobe is low, each output register takes its staging value. A disabled channel stays disabled.
- R11: After reset, all four registers are zero, both channels are enabled, both terminations select the high-resistance load, the bias is on and the error output is low.
- R12: A word with a bit count other than 16, or with a sub-bit of 1, changes no state. It raises the error output for exactly one cycle.
- R13: Opcode 000 words with any other D11..D9 pattern are accepted and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_cs_ni | input | 1 | Serial select, active low |
| spi_sck_i | input | 1 | Serial clock |
| spi_sdi_i | input | 1 | Serial data |
| load_ni | input | 1 | Active-low load strobe |
| code_a_o | output | 12 | Output register A |
| code_b_o | output | 12 | Output register B |
| en_a_o | output | 1 | Channel A enabled |
| en_b_o | output | 1 | Channel B enabled |
| term_hi_a_o | output | 1 | Channel A termination select, 1 = high-resistance |
| term_hi_b_o | output | 1 | Channel B termination select, 1 = high-resistance |
| bias_en_o | output | 1 | Shared bias enabled |
| frame_err_o | output | 1 | One-cycle pulse on a discarded word |

## Verification
The bench covers the cases where the staging and output paths interact:
- Load-and-update opcodes must copy the freshly written staging value, not the old one. A design that got this wrong would show the stale code on the output.
- An opcode 111 sent during full power-down must leave the bias off. A design that ignored this would reach the both-shutdown state with the bias running.
- The load strobe must not wake a disabled channel. A design that woke it would assert the enable.
- Short, long and sub-bit-set words must each leave every output unchanged and produce exactly one error pulse. Clock activity with select high must not shift data in.
- Reserved opcode 000 patterns must be no-ops. Mis-decoding them would change an enable or a code.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned OP_W   = 3;

  typedef struct packed {
    logic wr_in;    // write staging from payload
    logic upd;      // output <= staging (after write), wakes channel
    logic shut;     // disable channel
    logic term_we;
    logic term_val;
  } chan_cmd_t;

  typedef struct packed {
    chan_cmd_t [NUM_CH-1:0] ch;   // [0] = A, [1] = B
    logic                   bias_off;
  } dac_cmd_t;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_err_o
);
  localparam int unsigned CNT_MAX = FRAME_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic               sck_q, cs_q, err_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic               sck_rise, cs_rise, good;

  assign sck_rise = sck_i & ~sck_q;
  assign cs_rise  = cs_n_i & ~cs_q;
  assign good     = cs_rise && (cnt_q == CNT_W'(FRAME_W)) && !sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
      err_q <= cs_rise && !good;
      if (cs_n_i) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        sh_q <= {sh_q[FRAME_W-2:0], sdi_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_vld_o = good;
  assign frame_o     = sh_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned FRAME_W = OP_W + CODE_W + 1
) (
  input  logic [FRAME_W-1:0] frame_i,
  output dac_cmd_t           cmd_o,
  output logic [CODE_W-1:0]  data_o
);
  logic [OP_W-1:0]   op;
  logic [CODE_W-1:0] d;
  logic [2:0]        sub;

  assign op     = frame_i[FRAME_W-1 -: OP_W];
  assign d      = frame_i[FRAME_W-OP_W-1 -: CODE_W];
  assign sub    = d[CODE_W-1 -: 3];
  assign data_o = d;

  always_comb begin
    cmd_o = '0;
    unique case (op)
      3'b010: cmd_o.ch[0].wr_in = 1'b1;
      3'b101: cmd_o.ch[1].wr_in = 1'b1;
      3'b001: begin
        cmd_o.ch[0].wr_in = 1'b1;
        cmd_o.ch[0].upd   = 1'b1;
        cmd_o.ch[1].upd   = 1'b1;
      end
      3'b110: begin
        cmd_o.ch[1].wr_in = 1'b1;
        cmd_o.ch[0].upd   = 1'b1;
        cmd_o.ch[1].upd   = 1'b1;
      end
      3'b011: begin
        for (int i = 0; i < NUM_CH; i++) begin
          cmd_o.ch[i].wr_in = 1'b1;
          cmd_o.ch[i].upd   = 1'b1;
        end
      end
      3'b100: begin
        cmd_o.ch[0].upd = 1'b1;
        cmd_o.ch[1].upd = 1'b1;
      end
      3'b111: begin
        for (int i = 0; i < NUM_CH; i++) begin
          cmd_o.ch[i].shut    = 1'b1;
          cmd_o.ch[i].term_we = 1'b1;
        end
        cmd_o.ch[0].term_val = d[CODE_W-1];
        cmd_o.ch[1].term_val = d[CODE_W-2];
      end
      default: begin // extended opcode 000
        case (sub)
          3'b001: cmd_o.ch[0].upd = 1'b1;
          3'b101: cmd_o.ch[1].upd = 1'b1;
          3'b011: begin
            cmd_o.bias_off = 1'b1;
            for (int i = 0; i < NUM_CH; i++) begin
              cmd_o.ch[i].shut    = 1'b1;
              cmd_o.ch[i].term_we = 1'b1;
            end
            cmd_o.ch[0].term_val = d[CODE_W-4];
            cmd_o.ch[1].term_val = d[CODE_W-5];
          end
          3'b110: begin
            cmd_o.ch[0].shut     = 1'b1;
            cmd_o.ch[0].term_we  = 1'b1;
            cmd_o.ch[0].term_val = d[CODE_W-4];
          end
          3'b111: begin
            cmd_o.ch[1].shut     = 1'b1;
            cmd_o.ch[1].term_we  = 1'b1;
            cmd_o.ch[1].term_val = d[CODE_W-4];
          end
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  chan_cmd_t         cmd_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              load_i,
  output logic [CODE_W-1:0] code_o,
  output logic              en_o,
  output logic              term_hi_o
);
  logic [CODE_W-1:0] in_q, in_nxt, dac_q;
  logic              en_q, term_q;

  assign in_nxt = (cmd_vld_i && cmd_i.wr_in) ? data_i : in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      dac_q  <= '0;
      en_q   <= 1'b1;
      term_q <= 1'b1;
    end else begin
      in_q <= in_nxt;
      if ((cmd_vld_i && cmd_i.upd) || load_i) dac_q <= in_nxt;
      if (cmd_vld_i && cmd_i.upd)       en_q <= 1'b1;
      else if (cmd_vld_i && cmd_i.shut) en_q <= 1'b0;
      if (cmd_vld_i && cmd_i.term_we) term_q <= cmd_i.term_val;
    end
  end

  assign code_o    = dac_q;
  assign en_o      = en_q;
  assign term_hi_o = term_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_cs_ni,
  input  logic              spi_sck_i,
  input  logic              spi_sdi_i,
  input  logic              load_ni,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              en_a_o,
  output logic              en_b_o,
  output logic              term_hi_a_o,
  output logic              term_hi_b_o,
  output logic              bias_en_o,
  output logic              frame_err_o
);
  localparam int unsigned FRAME_W = OP_W + CODE_W + 1;

  logic [3:0]         pins_s;
  logic               cs_s, sck_s, sdi_s, load_act;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame;
  dac_cmd_t           cmd;
  logic [CODE_W-1:0]  data;
  logic               bias_q, any_upd;

  logic [CODE_W-1:0]  code [NUM_CH];
  logic [NUM_CH-1:0]  en, term_hi;

  dac_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_cs_ni, spi_sck_i, spi_sdi_i, load_ni}),
    .q_o   (pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s[3:1];
  assign load_act = ~pins_s[0];

  dac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_s),
    .sck_i      (sck_s),
    .sdi_i      (sdi_s),
    .frame_vld_o(frame_vld),
    .frame_o    (frame),
    .frame_err_o(frame_err_o)
  );

  dac_cmd_decode #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_dec (
    .frame_i(frame),
    .cmd_o  (cmd),
    .data_o (data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_vld_i(frame_vld),
      .cmd_i    (cmd.ch[g]),
      .data_i   (data),
      .load_i   (load_act),
      .code_o   (code[g]),
      .en_o     (en[g]),
      .term_hi_o(term_hi[g])
    );
  end

  assign any_upd = cmd.ch[0].upd | cmd.ch[1].upd;

  // Bias: off only by full power-down, back on by any wake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bias_q <= 1'b1;
    else if (frame_vld && cmd.bias_off) bias_q <= 1'b0;
    else if (frame_vld && any_upd)      bias_q <= 1'b1;
  end

  assign code_a_o    = code[0];
  assign code_b_o    = code[1];
  assign en_a_o      = en[0];
  assign en_b_o      = en[1];
  assign term_hi_a_o = term_hi[0];
  assign term_hi_b_o = term_hi[1];
  assign bias_en_o   = bias_q;
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld,
  input logic              load_act,
  input logic              frame_err_o,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              en_a_o,
  input logic              en_b_o,
  input logic              bias_en_o
);
  // R12
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  // R12
  err_vs_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld |=> !frame_err_o);

  // R9
  bias_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_o || en_b_o) |-> bias_en_o);

  // R2
  code_a_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_a_o) |-> $past(frame_vld || load_act));

  // R2
  code_b_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_b_o) |-> $past(frame_vld || load_act));

  // R10
  wake_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_a_o) |-> $past(frame_vld));

  // R10
  wake_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_b_o) |-> $past(frame_vld));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_vld  (frame_vld),
  .load_act   (load_act),
  .frame_err_o(frame_err_o),
  .code_a_o   (code_a_o),
  .code_b_o   (code_b_o),
  .en_a_o     (en_a_o),
  .en_b_o     (en_b_o),
  .bias_en_o  (bias_en_o)
);

// File: tb/sim_dual_dac_ctrl.sv
module sim_dual_dac_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, load_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic        en_a, en_b, th_a, th_b, bias, ferr;

  int checks = 0, errors = 0, err_seen = 0;

  typedef struct {
    logic [11:0] ca, cb;
    logic [4:0]  flags; // {en_a, en_b, th_a, th_b, bias}
    int          errs;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  // reference model
  logic [11:0] m_ia, m_ib, m_da, m_db;
  logic        m_ea, m_eb, m_ta, m_tb, m_bias;
  int          m_errs;

  always #4 clk = ~clk;

  dual_dac_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sck_i(sck),
    .spi_sdi_i(sdi), .load_ni(load_n), .code_a_o(code_a), .code_b_o(code_b),
    .en_a_o(en_a), .en_b_o(en_b), .term_hi_a_o(th_a), .term_hi_b_o(th_b),
    .bias_en_o(bias), .frame_err_o(ferr)
  );

  always @(negedge clk) if (rst_n && ferr) err_seen++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input string req);
    exp_t e;
    e.ca = m_da; e.cb = m_db;
    e.flags = {m_ea, m_eb, m_ta, m_tb, m_bias};
    e.errs = m_errs; e.req = req;
    exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compare once the result has settled through the synchronizers
  initial forever begin
    @(negedge clk);
    if (exp_q.size() != 0) begin
      exp_t e;
      repeat (12) @(negedge clk);
      e = exp_q[0];
      chk(e.req, "code_a", int'(code_a), int'(e.ca));
      chk(e.req, "code_b", int'(code_b), int'(e.cb));
      chk(e.req, "flags{en_a,en_b,th_a,th_b,bias}",
          int'({en_a, en_b, th_a, th_b, bias}), int'(e.flags));
      chk(e.req, "error pulses", err_seen, e.errs);
      void'(exp_q.pop_front());
    end
  end

  task automatic model(input logic [15:0] w);
    logic [2:0]  op;
    logic [11:0] d;
    op = w[15:13]; d = w[12:1];
    case (op)
      3'b010: m_ia = d;
      3'b101: m_ib = d;
      3'b001, 3'b110, 3'b011, 3'b100: begin
        if (op == 3'b001 || op == 3'b011) m_ia = d;
        if (op == 3'b110 || op == 3'b011) m_ib = d;
        m_da = m_ia; m_db = m_ib;
        m_ea = 1; m_eb = 1; m_bias = 1;
      end
      3'b111: begin m_ea = 0; m_eb = 0; m_ta = d[11]; m_tb = d[10]; end
      default: case (d[11:9])
        3'b001: begin m_da = m_ia; m_ea = 1; m_bias = 1; end
        3'b101: begin m_db = m_ib; m_eb = 1; m_bias = 1; end
        3'b011: begin m_ea = 0; m_eb = 0; m_bias = 0; m_ta = d[8]; m_tb = d[7]; end
        3'b110: begin m_ea = 0; m_ta = d[8]; end
        3'b111: begin m_eb = 0; m_tb = d[8]; end
        default: ;
      endcase
    endcase
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input string req);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    if (nbits == 16 && !w[0]) model(w);
    else m_errs++;
    push(req);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] d);
    return {op, d, 1'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_ia = 0; m_ib = 0; m_da = 0; m_db = 0;
    m_ea = 1; m_eb = 1; m_ta = 1; m_tb = 1; m_bias = 1; m_errs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push("R11");                                  // reset state
    send(mk(3'b010, 12'h123), 16, "R3");          // staging A only
    send(mk(3'b100, 12'h000), 16, "R5");          // copy both
    send(mk(3'b101, 12'hABC), 16, "R3");          // staging B only
    send(mk(3'b110, 12'h456), 16, "R4");          // B write + update both
    send(mk(3'b001, 12'hFFF), 16, "R4");          // A write + update both
    send(mk(3'b011, 12'h5A5), 16, "R5");          // broadcast
    send(mk(3'b111, 12'h400), 16, "R7");          // shut both, A low-R, B high-R
    send(mk(3'b010, 12'h0F0), 16, "R1");
    send(mk(3'b000, 12'h200), 16, "R6");          // wake A from staging A
    send(mk(3'b000, 12'hD00), 16, "R8");          // shut A, term 1
    send(mk(3'b000, 12'h600), 16, "R9");          // full power-down, terms 0/0
    send(mk(3'b111, 12'hC00), 16, "R9");          // bias must stay off
    send(mk(3'b101, 12'h777), 16, "R3");
    send(mk(3'b000, 12'hA00), 16, "R6");          // wake B -> bias on
    send(mk(3'b000, 12'hE00), 16, "R8");          // shut B, term 0
    send(mk(3'b000, 12'h400), 16, "R13");         // reserved pattern
    send(mk(3'b000, 12'h800), 16, "R13");         // reserved pattern
    send(mk(3'b010, 12'h321), 16, "R3");
    // load strobe with both channels asleep
    send(mk(3'b000, 12'hC00), 16, "R8");          // shut A
    load_n = 1'b0;
    repeat (6) @(negedge clk);
    load_n = 1'b1;
    m_da = m_ia; m_db = m_ib;
    push("R10");
    // malformed words
    send(mk(3'b011, 12'h111), 15, "R12");
    send(mk(3'b011, 12'h222), 17, "R12");
    send({3'b011, 12'h333, 1'b1}, 16, "R12");
    // clock and data activity with select high
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    sdi = 1'b0;
    push("R2");
    send(mk(3'b011, 12'h9C3), 16, "R2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule